// File: doc/BRIEF.md
# Mailbox Doorbell Character Channel

This block is the local end of a byte console that shares four 32-bit registers with a remote host: an inbound and an outbound mailbox, and an inbound and an outbound doorbell. The host posts a message code in the inbound doorbell. The block handles that code in the next cycle and then zeroes the doorbell. Characters that arrive with a data message go into a 256-entry receive ring. When the ring comes close to full, the block stops zeroing the inbound mailbox. Because the host only posts into an empty mailbox, this holds the host back until the local reader has drained the ring.

Local software reads through a valid/take byte interface and writes through a valid/ready byte interface. A transmitted byte waits for an empty outbound mailbox. It is then posted with bit 31 set, and the outbound doorbell carries the data code. The host reaches the shared registers through a simple select/write port with a combinational read.

Top module: `dbl_char_link`

## Requirements
- R1: After reset the four shared registers read zero, `rx_valid` is 0, `tx_ready` is 1, and `link_up` and `err_flag` are 0. Register selects: 0 is the inbound mailbox, 1 the outbound mailbox, 2 the inbound doorbell, 3 the outbound doorbell.
- R2: An inbound doorbell code of 1 (ping) makes the block write 1 to the outbound doorbell. This happens in the cycle after the doorbell was written.
- R3: Code 2 (connect) empties the receive ring, clears the near-full state, zeroes the inbound mailbox and raises `link_up`. Code 3 (disconnect) lowers `link_up`.
- R4: Code 5 (data) appends bits 7:0 of the inbound mailbox to the ring. Bytes leave in arrival order, and the ring indices wrap after 256 entries.
- R5: After a byte is stored, the inbound mailbox is zeroed while the ring holds 252 entries or fewer. Once the ring holds more than 252 entries, the block enters the near-full state and leaves the mailbox untouched.
- R6: In the near-full state, a take that leaves fewer than 252 entries ends that state and zeroes the inbound mailbox. A take that leaves exactly 252 entries does neither.
- R7: The block zeroes the inbound doorbell once it has handled the code. A host write to the outbound doorbell clears every bit that is 1 in the written data.
- R8: A byte from the local writer is posted only while the outbound mailbox reads zero. The posted word is 0x80000000 OR the byte, and the outbound doorbell is set to 5 at the same time.
- R9: After posting a newline (0x0A), the block posts a carriage return (0x0D) on its own.
- R10: `rx_valid` is 1 only while the ring holds at least one byte. A take on an empty ring has no effect.
- R11: Any other nonzero inbound doorbell code is zeroed and sets the sticky `err_flag`. It leaves the ring, the mailboxes, the outbound doorbell and `link_up` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_wsel | input | 2 | Host write register select |
| host_wdata | input | 32 | Host write data |
| host_rsel | input | 2 | Host read register select |
| host_rdata | output | 32 | Host read data (combinational) |
| rx_byte | output | 8 | Oldest byte in the receive ring |
| rx_valid | output | 1 | Receive ring not empty |
| rx_take | input | 1 | Consume the oldest byte |
| tx_byte | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte accepted when valid |
| link_up | output | 1 | Link connected |
| err_flag | output | 1 | Sticky unknown-code flag |

## Verification
The assertions check the following on every cycle: a post never happens while the outbound mailbox is occupied, ping replies and data posts land in the outbound doorbell, handled doorbells are zeroed, the near-full state only occurs with at least 252 entries, and each newline is followed by a pending carriage return. The bench scenarios are needed for the rest. They check byte order across an index wrap, the exact entry counts at which the mailbox is held and released, a take on an empty ring, and the precise word and doorbell values the host sees for random and directed characters.

// File: rtl/dbl_pkg.sv
// Shared constants for the mailbox doorbell character channel.
// Assumes a 32-bit shared register width and 8-bit characters.
package dbl_pkg;
    localparam int          MBX_W      = 32;
    localparam int          CH_W       = 8;
    localparam logic [31:0] MSG_ALIVE  = 32'd1;
    localparam logic [31:0] MSG_CONN   = 32'd2;
    localparam logic [31:0] MSG_DISC   = 32'd3;
    localparam logic [31:0] MSG_DATA   = 32'd5;
    localparam logic [31:0] TX_MARK    = 32'h8000_0000;
    localparam logic [7:0]  CH_LF      = 8'h0A;
    localparam logic [7:0]  CH_CR      = 8'h0D;

    typedef enum logic [1:0] {
        SEL_IN_MBX  = 2'd0,
        SEL_OUT_MBX = 2'd1,
        SEL_IN_DB   = 2'd2,
        SEL_OUT_DB  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dbl_rx_ring.sv
// Receive ring with near-full throttle decision.
// What: stores pushed bytes, presents the oldest one, and says when the
// inbound mailbox may be zeroed. Assumes push and flush never coincide.
module dbl_rx_ring #(
    parameter int DEPTH    = 256,
    parameter int HEADROOM = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [dbl_pkg::CH_W-1:0] push_byte,
    input  logic                  pop,
    input  logic                  flush,
    output logic [dbl_pkg::CH_W-1:0] head_byte,
    output logic                  not_empty,
    output logic                  mbx_clear,
    output logic                  near_full
);
    localparam int         AW   = $clog2(DEPTH);
    localparam logic [AW:0] HI_L = (AW+1)'(DEPTH - HEADROOM);

    logic [dbl_pkg::CH_W-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic          full_q, full_d;
    logic [AW:0]   cnt, cnt_next;
    logic          pop_ok;

    assign not_empty = (wptr_q != rptr_q);
    assign head_byte = mem[rptr_q];
    assign near_full = full_q;
    assign pop_ok    = pop && not_empty;
    assign cnt       = {1'b0, AW'(wptr_q - rptr_q)};
    assign cnt_next  = cnt + (AW+1)'(push) - (AW+1)'(pop_ok);

    // Decide the next near-full state and whether the mailbox is released.
    always_comb begin
        full_d    = full_q;
        mbx_clear = 1'b0;
        if (flush) begin
            full_d    = 1'b0;
            mbx_clear = 1'b1;
        end else if (push) begin
            full_d    = (cnt_next > HI_L);
            mbx_clear = !(cnt_next > HI_L);
        end else if (pop_ok && full_q && (cnt_next < HI_L)) begin
            full_d    = 1'b0;
            mbx_clear = 1'b1;
        end
    end

    // Byte storage write port.
    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= push_byte;
    end

    // Index and near-full state registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (push)   wptr_q <= wptr_q + 1'b1;
            if (pop_ok) rptr_q <= rptr_q + 1'b1;
            full_q <= full_d;
        end
    end

    a_r5_full_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> (cnt >= HI_L));
    a_r4_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |=> (wptr_q == AW'($past(wptr_q) + 1'b1)));
    a_r10_empty_take_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && !push && !flush) |=> (rptr_q == $past(rptr_q)));
endmodule

// File: rtl/dbl_tx_post.sv
// Transmit poster with one-byte hold and automatic carriage return.
// What: accepts a byte, posts it once the outbound mailbox is empty, and
// queues a carriage return after a newline. Assumes the top grants the
// outbound doorbell to it whenever it posts.
module dbl_tx_post (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [dbl_pkg::CH_W-1:0] in_byte,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     ob_empty,
    output logic                     post,
    output logic [dbl_pkg::MBX_W-1:0] post_word
);
    import dbl_pkg::*;

    logic            pend_q;
    logic [CH_W-1:0] hold_q;

    assign in_ready  = !pend_q;
    assign post      = pend_q && ob_empty;
    assign post_word = TX_MARK | MBX_W'(hold_q);

    // Hold register: load on accept, swap to CR after a posted LF.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hold_q <= '0;
        end else if (in_valid && in_ready) begin
            pend_q <= 1'b1;
            hold_q <= in_byte;
        end else if (post) begin
            if (hold_q == CH_LF) begin
                hold_q <= CH_CR;
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    a_r9_cr_follows_lf: assert property (@(posedge clk) disable iff (!rst_n)
        (post && hold_q == CH_LF) |=> (pend_q && hold_q == CH_CR));
endmodule

// File: rtl/dbl_msg_decode.sv
// Inbound doorbell decoder.
// What: turns a nonzero doorbell code into one action strobe and an
// acknowledge. Assumes the code is stable while busy holds it off.
module dbl_msg_decode (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [dbl_pkg::MBX_W-1:0] code,
    input  logic                      busy,
    output logic                      act,
    output logic                      do_push,
    output logic                      do_flush,
    output logic                      do_reply,
    output logic                      do_down,
    output logic                      do_err
);
    import dbl_pkg::*;

    assign act = (code != '0) && !busy;

    // Map the pending code to its action strobe.
    always_comb begin
        do_push  = 1'b0;
        do_flush = 1'b0;
        do_reply = 1'b0;
        do_down  = 1'b0;
        do_err   = 1'b0;
        if (act) begin
            case (code)
                MSG_ALIVE: do_reply = 1'b1;
                MSG_CONN:  do_flush = 1'b1;
                MSG_DISC:  do_down  = 1'b1;
                MSG_DATA:  do_push  = 1'b1;
                default:   do_err   = 1'b1;
            endcase
        end
    end

    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> $onehot({do_push, do_flush, do_reply, do_down, do_err}));
endmodule

// File: rtl/dbl_char_link.sv
// Mailbox doorbell character channel, top level.
// What: holds the four shared registers, routes doorbell actions to the
// receive ring and posts transmit bytes. Assumes the host writes the
// inbound mailbox only while it reads zero.
module dbl_char_link #(
    parameter int DEPTH    = 256,
    parameter int HEADROOM = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_wsel,
    input  logic [31:0] host_wdata,
    input  logic [1:0]  host_rsel,
    output logic [31:0] host_rdata,
    output logic [7:0]  rx_byte,
    output logic        rx_valid,
    input  logic        rx_take,
    input  logic [7:0]  tx_byte,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic        link_up,
    output logic        err_flag
);
    import dbl_pkg::*;

    logic [MBX_W-1:0] in_mbx_q, ob_mbx_q, in_db_q, ob_db_q;
    logic             link_q, err_q;
    logic             act, d_push, d_flush, d_reply, d_down, d_err;
    logic             tx_post, mbx_clr, near_full;
    logic [MBX_W-1:0] post_word;
    logic             wr_in_mbx, wr_ob_mbx, wr_in_db, wr_ob_db;

    assign wr_in_mbx = host_we && (reg_sel_e'(host_wsel) == SEL_IN_MBX);
    assign wr_ob_mbx = host_we && (reg_sel_e'(host_wsel) == SEL_OUT_MBX);
    assign wr_in_db  = host_we && (reg_sel_e'(host_wsel) == SEL_IN_DB);
    assign wr_ob_db  = host_we && (reg_sel_e'(host_wsel) == SEL_OUT_DB);

    dbl_msg_decode u_dec (
        .clk(clk), .rst_n(rst_n), .code(in_db_q), .busy(tx_post),
        .act(act), .do_push(d_push), .do_flush(d_flush),
        .do_reply(d_reply), .do_down(d_down), .do_err(d_err)
    );

    dbl_rx_ring #(.DEPTH(DEPTH), .HEADROOM(HEADROOM)) u_ring (
        .clk(clk), .rst_n(rst_n), .push(d_push), .push_byte(in_mbx_q[CH_W-1:0]),
        .pop(rx_take), .flush(d_flush), .head_byte(rx_byte),
        .not_empty(rx_valid), .mbx_clear(mbx_clr), .near_full(near_full)
    );

    dbl_tx_post u_tx (
        .clk(clk), .rst_n(rst_n), .in_byte(tx_byte), .in_valid(tx_valid),
        .in_ready(tx_ready), .ob_empty(ob_mbx_q == '0), .post(tx_post),
        .post_word(post_word)
    );

    // Shared registers: host writes win over block clears on inbound side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_mbx_q <= '0;
            ob_mbx_q <= '0;
            in_db_q  <= '0;
            ob_db_q  <= '0;
        end else begin
            if (wr_in_mbx)    in_mbx_q <= host_wdata;
            else if (mbx_clr) in_mbx_q <= '0;

            if (tx_post)        ob_mbx_q <= post_word;
            else if (wr_ob_mbx) ob_mbx_q <= host_wdata;

            if (wr_in_db) in_db_q <= host_wdata;
            else if (act) in_db_q <= '0;

            if (tx_post)       ob_db_q <= MSG_DATA;
            else if (d_reply)  ob_db_q <= MSG_ALIVE;
            else if (wr_ob_db) ob_db_q <= ob_db_q & ~host_wdata;
        end
    end

    // Link state and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (d_flush)     link_q <= 1'b1;
            else if (d_down) link_q <= 1'b0;
            if (d_err) err_q <= 1'b1;
        end
    end

    // Host read mux.
    always_comb begin
        case (reg_sel_e'(host_rsel))
            SEL_IN_MBX:  host_rdata = in_mbx_q;
            SEL_OUT_MBX: host_rdata = ob_mbx_q;
            SEL_IN_DB:   host_rdata = in_db_q;
            default:     host_rdata = ob_db_q;
        endcase
    end

    assign link_up  = link_q;
    assign err_flag = err_q;

    a_r8_wait_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_mbx_q != '0) |-> !tx_post);
    a_r8_post_marks: assert property (@(posedge clk) disable iff (!rst_n)
        tx_post |=> (ob_mbx_q[MBX_W-1] && ob_db_q == MSG_DATA));
    a_r2_ping_reply: assert property (@(posedge clk) disable iff (!rst_n)
        d_reply |=> (ob_db_q == MSG_ALIVE));
    a_r3_connect_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (d_flush && !wr_in_mbx) |=> (in_mbx_q == '0 && !rx_valid && link_q && !near_full));
    a_r7_db_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !wr_in_db) |=> (in_db_q == '0));
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: tb/tb_dbl_char_link.sv
module tb_dbl_char_link;
    import dbl_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_wsel = '0, host_rsel = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic [7:0]  rx_byte, tx_byte = '0;
    logic        rx_valid, rx_take = 1'b0, tx_valid = 1'b0, tx_ready;
    logic        link_up, err_flag;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q[$];

    dbl_char_link dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wsel(host_wsel),
        .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_take(rx_take),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .link_up(link_up), .err_flag(err_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_wsel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] sel, output logic [31:0] d);
        host_rsel = sel;
        #1;
        d = host_rdata;
    endtask

    // Expected mailbox word: any upper bits, byte in low 8, never zero.
    function automatic logic [31:0] mbx_word(input logic [7:0] b, input logic [31:0] r);
        return (r & 32'hFFFF_FF00) | 32'h100 | {24'h0, b};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        host_wr(SEL_IN_MBX, mbx_word(b, $urandom()));
        host_wr(SEL_IN_DB, MSG_DATA);
        @(negedge clk);
        exp_q.push_back(b);
    endtask

    task automatic pop_byte(input string req);
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(req, {31'h0, rx_valid}, 32'd1);
        chk(req, {24'h0, rx_byte}, {24'h0, e});
        rx_take = 1'b1;
        @(negedge clk);
        rx_take = 1'b0;
    endtask

    task automatic tx_send(input logic [7:0] b);
        while (!tx_ready) @(negedge clk);
        tx_byte = b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic host_take(input logic [7:0] b, input string req);
        logic [31:0] d;
        int t = 0;
        host_rd(SEL_OUT_MBX, d);
        while (d == 0 && t < 50) begin
            @(negedge clk);
            host_rd(SEL_OUT_MBX, d);
            t++;
        end
        chk(req, d, TX_MARK | {24'h0, b});
        host_rd(SEL_OUT_DB, d);
        chk(req, d, MSG_DATA);
        host_wr(SEL_OUT_DB, 32'hFFFF_FFFF);
        host_rd(SEL_OUT_DB, d);
        chk("R7 outbound doorbell clear", d, 32'h0);
        host_wr(SEL_OUT_MBX, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            host_rd(s[1:0], d);
            chk("R1 register zero", d, 32'h0);
        end
        chk("R1 rx_valid", {31'h0, rx_valid}, 32'd0);
        chk("R1 tx_ready", {31'h0, tx_ready}, 32'd1);
        chk("R1 link_up", {31'h0, link_up}, 32'd0);
        chk("R1 err_flag", {31'h0, err_flag}, 32'd0);

        // R2: ping reply, R7: inbound doorbell zeroed, outbound W1C
        host_wr(SEL_IN_DB, MSG_ALIVE);
        @(negedge clk);
        host_rd(SEL_OUT_DB, d);  chk("R2 ping reply", d, MSG_ALIVE);
        host_rd(SEL_IN_DB, d);   chk("R7 inbound doorbell zeroed", d, 32'h0);
        host_wr(SEL_OUT_DB, 32'h0000_0001);
        host_rd(SEL_OUT_DB, d);  chk("R7 W1C outbound", d, 32'h0);

        // R3: connect
        host_wr(SEL_IN_MBX, 32'hDEAD_0001);
        host_wr(SEL_IN_DB, MSG_CONN);
        @(negedge clk);
        chk("R3 link up", {31'h0, link_up}, 32'd1);
        host_rd(SEL_IN_MBX, d);  chk("R3 mailbox zeroed", d, 32'h0);

        // R11: unknown code
        host_wr(SEL_IN_DB, 32'd7);
        @(negedge clk);
        chk("R11 err sticky", {31'h0, err_flag}, 32'd1);
        host_rd(SEL_IN_DB, d);   chk("R11 code zeroed", d, 32'h0);
        host_rd(SEL_OUT_DB, d);  chk("R11 no reply", d, 32'h0);
        chk("R11 link kept", {31'h0, link_up}, 32'd1);
        chk("R11 ring untouched", {31'h0, rx_valid}, 32'd0);

        // R10: take on empty ring has no effect
        rx_take = 1'b1;
        @(negedge clk);
        rx_take = 1'b0;
        chk("R10 empty stays empty", {31'h0, rx_valid}, 32'd0);
        send_byte(8'h5A);
        pop_byte("R10 head after empty take");
        chk("R10 empty again", {31'h0, rx_valid}, 32'd0);

        // R4: random bytes with interleaved takes
        for (int i = 0; i < 20; i++) begin
            send_byte(8'($urandom_range(0, 255)));
            host_rd(SEL_IN_MBX, d);
            chk("R5 mailbox released", d, 32'h0);
            if ($urandom_range(0, 2) == 0) pop_byte("R4 order");
        end
        while (exp_q.size() > 0) pop_byte("R4 order");

        // R5/R6: fill to the throttle point
        for (int k = 1; k <= 253; k++) begin
            send_byte(8'($urandom_range(0, 255)));
            host_rd(SEL_IN_MBX, d);
            if (k <= 252) chk("R5 released at or below 252", {31'h0, d == 0}, 32'd1);
            else          chk("R5 held above 252", {31'h0, d != 0}, 32'd1);
        end
        pop_byte("R6 take to 252");
        host_rd(SEL_IN_MBX, d);
        chk("R6 still held at 252", {31'h0, d != 0}, 32'd1);
        pop_byte("R6 take to 251");
        host_rd(SEL_IN_MBX, d);
        chk("R6 released below 252", d, 32'h0);
        while (exp_q.size() > 0) pop_byte("R4 order across wrap");
        chk("R10 drained", {31'h0, rx_valid}, 32'd0);

        // R3: disconnect then reconnect with bytes pending
        host_wr(SEL_IN_DB, MSG_DISC);
        @(negedge clk);
        chk("R3 link down", {31'h0, link_up}, 32'd0);
        send_byte(8'h11); send_byte(8'h22);
        host_wr(SEL_IN_MBX, 32'h0000_1234);
        host_wr(SEL_IN_DB, MSG_CONN);
        @(negedge clk);
        exp_q.delete();
        chk("R3 ring emptied", {31'h0, rx_valid}, 32'd0);
        host_rd(SEL_IN_MBX, d);  chk("R3 mailbox zeroed", d, 32'h0);
        chk("R3 link up again", {31'h0, link_up}, 32'd1);

        // R8: second byte waits while mailbox occupied
        tx_send(8'h41);
        tx_send(8'h42);
        repeat (6) @(negedge clk);
        host_rd(SEL_OUT_MBX, d);
        chk("R8 waits for empty", d, TX_MARK | 32'h41);
        host_take(8'h41, "R8 first word");
        host_take(8'h42, "R8 second word");

        // R9: newline gets a carriage return
        tx_send(CH_LF);
        host_take(CH_LF, "R9 newline");
        host_take(CH_CR, "R9 carriage return");

        // R8/R9: random transmit stream
        for (int i = 0; i < 30; i++) begin
            logic [7:0] c;
            c = (i % 7 == 3) ? CH_LF : 8'($urandom_range(0, 255));
            tx_send(c);
            host_take(c, "R8 random post");
            if (c == CH_LF) host_take(CH_CR, "R9 random carriage return");
        end
        repeat (4) @(negedge clk);
        host_rd(SEL_OUT_MBX, d);
        chk("R9 no extra post", d, 32'h0);

        finish_run();
    end
endmodule